// File: doc/BRIEF.md
# Wide Floating-Point Multiplier

This block forms the product of two wide floating-point numbers every clock cycle. Each operand word holds a sign, a 63-bit biased exponent and a mantissa that fills the rest of the word. The total word width is a compile-time parameter. The significand product (mantissa with its hidden leading one) is built by a recursive three-product split-and-combine tree. Each level cuts its operands into a high and a low half and forms three partial products: high times high, low times low, and the product of the two half-sums. The middle term is recovered by subtraction. The recursion ends at a configurable base width, where a plain multiplier is used.

The datapath has no stalls. An operand pair presented with `in_valid` high appears as a result with `out_valid` high a fixed number of cycles later. Pairs can arrive back to back, and gaps in the input stream are reproduced at the output. Zero operands are recognised and give a signed zero. Other special values, exponent overflow and exponent underflow are not handled.

The latency is the multiplier-tree latency plus one output stage. The tree latency is computed as follows: start at 1; while the width w exceeds the base width, replace w with w - floor(w/2) + 1 and add 2. The base width must be at least 4.

Top module: `fpmul_wide`

## Requirements
- R1: Word layout. The sign is bit TOTAL_W-1. The exponent is bits TOTAL_W-2 down to TOTAL_W-64. The mantissa is bits TOTAL_W-65 down to 0. TOTAL_W is a multiple of 512, and the default is 512, which gives a 448-bit mantissa.
- R2: The result sign is the XOR of the two operand signs, and this also holds when the result is zero.
- R3: For non-zero results, the result exponent is ea + eb - (2^62 - 1), plus 1 when the significand product is at least 2. The sum is taken modulo 2^63, with no overflow or underflow detection.
- R4: Each significand is 1.mantissa. When the product is at least 2, it is shifted right by one. The result mantissa is the product truncated toward zero to the mantissa width.
- R5: An operand whose exponent and mantissa are both all zeros is zero. If either operand is zero, the result has all exponent and mantissa bits zero. An operand with a zero exponent but a non-zero mantissa is treated as an ordinary number.
- R6: Every accepted pair gives exactly one result with `out_valid` high, exactly LATENCY cycles later (8 cycles at the defaults), in input order. Back-to-back pairs and gaps in the input stream are preserved.
- R7: The split-and-combine multiplier returns the exact full-width product for every operand pair, including odd widths that split unevenly. A 7-bit instance with base width 4 has a latency of 5 cycles.
- R8: While reset is asserted, and afterwards until the first accepted pair reaches the output, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | TOTAL_W | First operand word |
| in_b | input | TOTAL_W | Second operand word |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | TOTAL_W | Product word |

## Verification
Faults in this block show up at the ports at the full pipeline latency, and the symptom depends on where the fault is:
- A misaligned padding delay or side-band register in the multiplier tree puts a result on the wrong pair's slot. This is seen as a sign, exponent or mantissa mismatch on the next back-to-back stream.
- A wrong middle-term subtraction or a wrong split point corrupts mantissa bits, usually low-order bits first. The exhaustive sweep of the small uneven instance catches this within a few hundred pairs.
- A wrong normalization choice gives a mantissa shifted by one place and an exponent off by one. Products of large mantissas expose this at once.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
    localparam int EXP_W = 63;

    // Cycles through a split-and-combine multiplier of width w.
    function automatic int kara_lat(input int w, input int base);
        int lat;
        int cur;
        lat = 1;
        cur = w;
        while (cur > base) begin
            cur = cur - cur / 2 + 1;
            lat = lat + 2;
        end
        return lat;
    endfunction
endpackage

// File: rtl/fpm_delay.sv
`timescale 1ns/1ps
module fpm_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    if (DEPTH == 0) begin : g_wire
        logic unused_ctl;
        assign unused_ctl = clk ^ rst_n;
        assign q = d;
    end else begin : g_regs
        logic [W-1:0] sr [DEPTH];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
            end else begin
                sr[0] <= d;
                for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
            end
        end
        assign q = sr[DEPTH-1];
    end
endmodule

// File: rtl/fpm_kara.sv
`timescale 1ns/1ps
module fpm_kara #(
    parameter int W      = 64,
    parameter int BASE_W = 64
) (
    input  logic           clk,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    if (W <= BASE_W) begin : g_base
        logic [PW-1:0] p_q;
        always_ff @(posedge clk) begin
            p_q <= {{W{1'b0}}, a} * {{W{1'b0}}, b};
        end
        assign p = p_q;
    end else begin : g_split
        localparam int LO     = W / 2;
        localparam int HI     = W - LO;
        localparam int MW     = HI + 1;
        localparam int LAT_HI = fpm_pkg::kara_lat(HI, BASE_W);
        localparam int LAT_LO = fpm_pkg::kara_lat(LO, BASE_W);
        localparam int LAT_MD = fpm_pkg::kara_lat(MW, BASE_W);

        logic [HI-1:0]   ah_q, bh_q;
        logic [LO-1:0]   al_q, bl_q;
        logic [MW-1:0]   as_q, bs_q;
        logic [2*HI-1:0] z_hi, z_hi_d;
        logic [2*LO-1:0] z_lo, z_lo_d;
        logic [2*MW-1:0] z_md;
        logic [PW-1:0]   p_q;

        // stage: split and pre-add
        always_ff @(posedge clk) begin
            ah_q <= a[W-1:LO];
            bh_q <= b[W-1:LO];
            al_q <= a[LO-1:0];
            bl_q <= b[LO-1:0];
            as_q <= MW'(a[W-1:LO]) + MW'(a[LO-1:0]);
            bs_q <= MW'(b[W-1:LO]) + MW'(b[LO-1:0]);
        end

        fpm_kara #(.W(HI), .BASE_W(BASE_W)) u_hi (.clk(clk), .a(ah_q), .b(bh_q), .p(z_hi));
        fpm_kara #(.W(LO), .BASE_W(BASE_W)) u_lo (.clk(clk), .a(al_q), .b(bl_q), .p(z_lo));
        fpm_kara #(.W(MW), .BASE_W(BASE_W)) u_md (.clk(clk), .a(as_q), .b(bs_q), .p(z_md));

        // pad the shorter branches to the middle branch depth
        fpm_delay #(.W(2*HI), .DEPTH(LAT_MD - LAT_HI)) u_pad_hi (
            .clk(clk), .rst_n(1'b1), .d(z_hi), .q(z_hi_d));
        fpm_delay #(.W(2*LO), .DEPTH(LAT_MD - LAT_LO)) u_pad_lo (
            .clk(clk), .rst_n(1'b1), .d(z_lo), .q(z_lo_d));

        // stage: recombine
        always_ff @(posedge clk) begin
            p_q <= (PW'(z_hi_d) << (2 * LO))
                 + ((PW'(z_md) - PW'(z_hi_d) - PW'(z_lo_d)) << LO)
                 + PW'(z_lo_d);
        end
        assign p = p_q;
    end
endmodule

// File: rtl/fpm_norm.sv
`timescale 1ns/1ps
module fpm_norm #(
    parameter int MAN_W = 448,
    parameter int EXP_W = 63
) (
    input  logic [MAN_W+1:0]       prod_hi,
    input  logic                   zero,
    input  logic                   sign,
    input  logic [EXP_W-1:0]       esum,
    output logic [MAN_W+EXP_W:0]   result
);
    logic             carry;
    logic [MAN_W-1:0] man;
    logic [EXP_W-1:0] expo;

    always_comb begin
        carry = prod_hi[MAN_W+1];
        man   = carry ? prod_hi[MAN_W:1] : prod_hi[MAN_W-1:0];
        expo  = esum + EXP_W'(carry);
        if (zero) result = {sign, {(MAN_W+EXP_W){1'b0}}};
        else      result = {sign, expo, man};
    end
endmodule

// File: rtl/fpmul_wide.sv
`timescale 1ns/1ps
module fpmul_wide #(
    parameter int TOTAL_W = 512,
    parameter int BASE_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [TOTAL_W-1:0] in_a,
    input  logic [TOTAL_W-1:0] in_b,
    output logic               out_valid,
    output logic [TOTAL_W-1:0] out_result
);
    localparam int EXP_W  = fpm_pkg::EXP_W;
    localparam int MAN_W  = TOTAL_W - 1 - EXP_W;
    localparam int SIG_W  = MAN_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int LAT_K  = fpm_pkg::kara_lat(SIG_W, BASE_W);
    localparam int SIDE_W = EXP_W + 2;
    localparam logic [EXP_W-1:0] BIAS = {1'b0, {(EXP_W-1){1'b1}}};

    if (TOTAL_W % 512 != 0) begin : g_bad_width
        $error("TOTAL_W must be a multiple of 512");
    end
    if (BASE_W < 4) begin : g_bad_base
        $error("BASE_W must be at least 4");
    end

    logic               sgn_a, sgn_b, zero_in;
    logic [EXP_W-1:0]   exp_a, exp_b, esum_in;
    logic [MAN_W-1:0]   man_a, man_b;
    logic [SIDE_W-1:0]  side_in, side_d;
    logic               vld_d;
    logic [PROD_W-1:0]  prod;
    logic [TOTAL_W-1:0] res;
    logic               unused_prod_lo;

    always_comb begin
        sgn_a   = in_a[TOTAL_W-1];
        sgn_b   = in_b[TOTAL_W-1];
        exp_a   = in_a[TOTAL_W-2 -: EXP_W];
        exp_b   = in_b[TOTAL_W-2 -: EXP_W];
        man_a   = in_a[MAN_W-1:0];
        man_b   = in_b[MAN_W-1:0];
        zero_in = (exp_a == '0 && man_a == '0) || (exp_b == '0 && man_b == '0);
        esum_in = exp_a + exp_b - BIAS;
        side_in = {zero_in, sgn_a ^ sgn_b, esum_in};
    end

    fpm_kara #(.W(SIG_W), .BASE_W(BASE_W)) u_mul (
        .clk(clk), .a({1'b1, man_a}), .b({1'b1, man_b}), .p(prod));

    fpm_delay #(.W(SIDE_W), .DEPTH(LAT_K)) u_side (
        .clk(clk), .rst_n(rst_n), .d(side_in), .q(side_d));

    fpm_delay #(.W(1), .DEPTH(LAT_K)) u_vld (
        .clk(clk), .rst_n(rst_n), .d(in_valid), .q(vld_d));

    assign unused_prod_lo = ^prod[MAN_W-1:0];

    fpm_norm #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_norm (
        .prod_hi(prod[PROD_W-1:MAN_W]),
        .zero(side_d[SIDE_W-1]),
        .sign(side_d[SIDE_W-2]),
        .esum(side_d[EXP_W-1:0]),
        .result(res));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= vld_d;
            out_result <= res;
        end
    end
endmodule

// File: rtl/fpmul_wide_chk.sv
`timescale 1ns/1ps
module fpmul_wide_chk #(
    parameter int TOTAL_W = 512,
    parameter int BASE_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [TOTAL_W-1:0] in_a,
    input logic [TOTAL_W-1:0] in_b,
    input logic               out_valid,
    input logic [TOTAL_W-1:0] out_result
);
    localparam int EXP_W = fpm_pkg::EXP_W;
    localparam int MAN_W = TOTAL_W - 1 - EXP_W;
    localparam int LAT   = fpm_pkg::kara_lat(MAN_W + 1, BASE_W) + 1;
    localparam logic [EXP_W-1:0] BIAS = {1'b0, {(EXP_W-1){1'b1}}};

    logic             vld_sh  [LAT];
    logic             sgn_sh  [LAT];
    logic             zero_sh [LAT];
    logic [EXP_W-1:0] esum_sh [LAT];
    logic             a_zero, b_zero;
    logic [EXP_W-1:0] exp_gap;

    assign a_zero  = (in_a[TOTAL_W-2:0] == '0);
    assign b_zero  = (in_b[TOTAL_W-2:0] == '0);
    assign exp_gap = out_result[TOTAL_W-2 -: EXP_W] - esum_sh[LAT-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                vld_sh[i]  <= 1'b0;
                sgn_sh[i]  <= 1'b0;
                zero_sh[i] <= 1'b0;
                esum_sh[i] <= '0;
            end
        end else begin
            vld_sh[0]  <= in_valid;
            sgn_sh[0]  <= in_a[TOTAL_W-1] ^ in_b[TOTAL_W-1];
            zero_sh[0] <= a_zero | b_zero;
            esum_sh[0] <= in_a[TOTAL_W-2 -: EXP_W] + in_b[TOTAL_W-2 -: EXP_W] - BIAS;
            for (int i = 1; i < LAT; i++) begin
                vld_sh[i]  <= vld_sh[i-1];
                sgn_sh[i]  <= sgn_sh[i-1];
                zero_sh[i] <= zero_sh[i-1];
                esum_sh[i] <= esum_sh[i-1];
            end
        end
    end

    // R6 R8: output valid follows input valid by the fixed latency
    p_valid_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vld_sh[LAT-1]);

    // R2: sign of each delivered result
    p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_result[TOTAL_W-1] == sgn_sh[LAT-1]);

    // R5: zero operand gives clear exponent and mantissa
    p_zero_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zero_sh[LAT-1]) |-> out_result[TOTAL_W-2:0] == '0);

    // R3: exponent is the unbiased sum or one more
    p_exp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !zero_sh[LAT-1]) |-> (exp_gap == '0 || exp_gap == EXP_W'(1)));
endmodule

bind fpmul_wide fpmul_wide_chk #(.TOTAL_W(TOTAL_W), .BASE_W(BASE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result));

// File: tb/test_fpmul_wide.sv
`timescale 1ns/1ps
module test_fpmul_wide;
    localparam int W    = 512;
    localparam int E    = 63;
    localparam int M    = W - 1 - E;
    localparam int LAT  = 8;
    localparam int KLAT = 5;
    localparam logic [E-1:0] BIAS = {1'b0, {(E-1){1'b1}}};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic [6:0]   ka = '0, kb = '0;
    logic [13:0]  kp;

    int checks = 0, fails = 0, cyc = 0;
    logic [W-1:0] exp_q [$];
    int           t_q   [$];
    bit           z_q   [$];
    logic [13:0]  kexp [8];
    bit           kv   [8];

    fpmul_wide i_fpmul_wide (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result));
    fpm_kara #(.W(7), .BASE_W(4)) i_kara (.clk(clk), .a(ka), .b(kb), .p(kp));

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_zero(input logic [W-1:0] x);
        return x[W-2:0] == '0;
    endfunction

    // R1 field layout: sign at W-1, exponent next 63 bits, mantissa below
    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*M+1:0] p;
        logic [E-1:0]   e;
        logic [M-1:0]   m;
        logic           s;
        s = a[W-1] ^ b[W-1];
        if (is_zero(a) || is_zero(b)) return {s, {(W-1){1'b0}}};
        p = {{(M+1){1'b0}}, 1'b1, a[M-1:0]} * {{(M+1){1'b0}}, 1'b1, b[M-1:0]};
        e = a[W-2 -: E] + b[W-2 -: E] - BIAS + E'(p[2*M+1]);
        m = p[2*M+1] ? p[2*M:M+1] : p[2*M-1:M];
        return {s, e, m};
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] x;
        for (int i = 0; i < W / 32; i++) x[i*32 +: 32] = $urandom();
        return x;
    endfunction

    function automatic logic [W-1:0] mk(input bit s, input logic [E-1:0] e,
                                        input logic [M-1:0] m);
        return {s, e, m};
    endfunction

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b;
        exp_q.push_back(model(a, b));
        t_q.push_back(cyc);
        z_q.push_back(is_zero(a) || is_zero(b));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_a = rnd_word(); in_b = rnd_word();
    endtask

    // output monitor for the floating-point top
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 result with no pending pair", W'(1), W'(0));
            end else begin
                logic [W-1:0] e;
                int t;
                bit z;
                e = exp_q.pop_front(); t = t_q.pop_front(); z = z_q.pop_front();
                check(cyc - t == LAT, "R6 latency", W'(cyc - t), W'(LAT));
                check(out_result[W-1] == e[W-1], "R2 sign", W'(out_result[W-1]), W'(e[W-1]));
                check(out_result[W-2 -: E] == e[W-2 -: E], "R3 exponent",
                      W'(out_result[W-2 -: E]), W'(e[W-2 -: E]));
                check(out_result[M-1:0] == e[M-1:0], "R4 mantissa",
                      W'(out_result[M-1:0]), W'(e[M-1:0]));
                if (z) check(out_result[W-2:0] == '0, "R5 zero result",
                             out_result, {out_result[W-1], {(W-1){1'b0}}});
                check(out_result == e, "R1 full word", out_result, e);
            end
        end
    end

    // output monitor for the exhaustive multiplier sweep
    always @(negedge clk) begin
        if (kv[(cyc + 8 - KLAT) % 8])
            check(kp == kexp[(cyc + 8 - KLAT) % 8], "R7 exact product",
                  W'(kp), W'(kexp[(cyc + 8 - KLAT) % 8]));
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] one, big, zp, zn, odd;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) kv[i] = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8 valid low in reset", W'(out_valid), W'(0));
        end
        rst_n = 1'b1;
        repeat (12) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R8 valid low before first pair", W'(out_valid), W'(0));
        end

        one = mk(1'b0, BIAS, '0);
        big = mk(1'b0, BIAS, {M{1'b1}});
        zp  = '0;
        zn  = {1'b1, {(W-1){1'b0}}};
        odd = mk(1'b1, '0, M'(5));
        drive(one, one);                              // R4 1.0 * 1.0
        drive(big, big);                              // R3 R4 carry into bit above
        drive(mk(1'b1, BIAS + 1, '0), one);           // R2 negative times positive
        drive(zp, big);                               // R5 zero first
        drive(big, zn);                               // R5 R2 negative zero second
        drive(zn, zn);                                // R5 R2 two negative zeros
        drive(odd, one);                              // R5 zero exponent, nonzero mantissa
        drive(mk(1'b0, {E{1'b1}}, '1), mk(1'b1, {E{1'b1}}, '1)); // R3 wrap
        drive(mk(1'b0, BIAS, {1'b1, {(M-1){1'b0}}}), mk(1'b0, BIAS, {1'b1, {(M-1){1'b0}}}));
        idle(); idle();
        drive(big, one);                              // R6 after a gap

        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] a, b;
            a = rnd_word(); b = rnd_word();
            if ($urandom_range(0, 31) == 0) a[W-2:0] = '0;
            if ($urandom_range(0, 3) == 0) idle();
            drive(a, b);
        end
        idle();
        repeat (LAT + 2) idle();
        check(exp_q.size() == 0, "R6 every pair delivered", W'(exp_q.size()), W'(0));
        check(out_valid == 1'b0, "R6 valid drops after stream", W'(out_valid), W'(0));

        for (int i = 0; i < 16384 + KLAT; i++) begin
            @(negedge clk);
            if (i < 16384) begin
                ka = i[13:7]; kb = i[6:0];
                kexp[cyc % 8] = 14'(ka) * 14'(kb);
                kv[cyc % 8] = 1'b1;
            end else begin
                kv[cyc % 8] = 1'b0;
            end
        end
        @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule